// File: doc/BRIEF.md
# SPI Bulk Block Transfer Master

This block is an SPI master in mode 0, built to move whole data blocks to or from a memory card without per-byte processor work. Software sets a direction, a byte count and a clock divider, then pulses `start`. Chip select drops and the engine runs exactly the requested number of 8-bit frames. It then releases chip select and raises `done`.

In read mode the engine sends a constant all-ones fill byte in every frame, which it produces itself. Each captured byte goes to a DMA-style request/acknowledge pair. If that byte has not been acknowledged, the engine waits with the serial clock low and does not overwrite it. In write mode the engine asks for each outgoing byte through a second request/acknowledge pair and shifts it out. The bytes received during a write are dropped.

Top module: `spi_bulk_engine`

## Requirements
- R1: After reset, `cs_n`=1, `sclk`=0, `mosi`=1, and `done`, `busy`, `rx_req` and `tx_req` are all 0.
- R2: The serial clock idles low. Each high phase lasts `clk_div+1` system cycles. `mosi` changes only while `sclk` is low. Bits travel MSB first, and `miso` is captured on the rising edge.
- R3: In read mode (`write_mode`=0 at start), every frame shifted out on `mosi` is 8'hFF.
- R4: In read mode, each received byte appears on `rx_data` with `rx_req`=1. `rx_req` and `rx_data` hold until a cycle with `rx_ack`=1.
- R5: While a received byte is still unacknowledged, the engine stops between frames with `sclk` low and produces no clock edge.
- R6: In write mode (`write_mode`=1 at start), the engine raises `tx_req` once per frame. It takes `tx_data` in the cycle where `tx_ack`=1 and shifts that byte out MSB first. `rx_req` stays 0 for the whole write.
- R7: A transfer runs exactly `byte_count` frames, for any count from 1 up to at least 512. A start with a count of 0 sets `done` in the next cycle and leaves `cs_n` high.
- R8: `cs_n` is low for the whole transfer. It rises 2*(`clk_div`+1) cycles after the last frame completes. In write mode that point is the last falling `sclk` edge. In read mode it is the final acknowledge.
- R9: `done` rises together with the release of `cs_n` and stays set while idle. The next accepted start clears it.
- R10: A `start` pulse during a transfer is ignored. The running transfer keeps its direction and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a transfer |
| write_mode | input | 1 | 1 = write transfer, 0 = read with fill bytes |
| byte_count | input | CNT_W | Number of frames to run |
| clk_div | input | DIV_W | Serial half period minus one, in system cycles |
| tx_data | input | 8 | Byte supplied for a write frame |
| tx_ack | input | 1 | Transmit byte is valid on `tx_data` |
| tx_req | output | 1 | Engine wants the next transmit byte |
| rx_data | output | 8 | Captured read byte |
| rx_req | output | 1 | `rx_data` holds an unacknowledged byte |
| rx_ack | input | 1 | Receiver has taken `rx_data` |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer has finished |

## Verification
The timing results have these deadlines:
- The high phase of `sclk` ends `clk_div+1` cycles after it starts.
- In a write, `cs_n` rises 2*(`clk_div`+1) cycles after the last falling `sclk` edge.
- After a zero-count start, `done` is due one cycle after the start.
- A received byte stays pending, with no clock edge, for as many cycles as its acknowledge is held back.

The bench samples on the falling system edge and counts elapsed cycles from the last observed `sclk` change. It compares each interval with the exact value above instead of waiting for an eventual match. Data checks compare every frame the bench captures against a pattern the bench generates from the seed.

// File: rtl/spi_bulk_engine.sv
module spi_bulk_engine #(
  parameter int CNT_W = 10,
  parameter int DIV_W = 4,
  parameter logic [7:0] FILL = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             write_mode,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [7:0]       tx_data,
  input  logic             tx_ack,
  output logic             tx_req,
  output logic [7:0]       rx_data,
  output logic             rx_req,
  input  logic             rx_ack,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n,
  output logic             busy,
  output logic             done
);
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SHIFT, S_HAND, S_FIN} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] div_q, div_cnt;
  logic [DIV_W:0]   fin;
  logic [2:0]       bitn;
  logic [7:0]       shreg, rxsh;
  logic             wr_q;

  assign mosi   = shreg[7];
  assign cs_n   = (st == S_IDLE);
  assign busy   = !cs_n;
  assign tx_req = (st == S_LOAD) && wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      div_q   <= '0;
      div_cnt <= '0;
      fin     <= '0;
      bitn    <= '0;
      shreg   <= FILL;
      rxsh    <= '0;
      rx_data <= '0;
      rx_req  <= 1'b0;
      sclk    <= 1'b0;
      wr_q    <= 1'b0;
      done    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          wr_q  <= write_mode;
          div_q <= clk_div;
          cnt   <= byte_count;
          if (byte_count == '0) done <= 1'b1;
          else begin
            done <= 1'b0;
            st   <= S_LOAD;
          end
        end
        S_LOAD: if (!wr_q || tx_ack) begin
          shreg   <= wr_q ? tx_data : FILL;
          div_cnt <= '0;
          bitn    <= '0;
          sclk    <= 1'b0;
          st      <= S_SHIFT;
        end
        S_SHIFT: begin
          if (div_cnt != div_q) div_cnt <= div_cnt + DIV_W'(1);
          else begin
            div_cnt <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
              rxsh <= {rxsh[6:0], miso};
            end else begin
              sclk  <= 1'b0;
              shreg <= {shreg[6:0], 1'b1};
              bitn  <= bitn + 3'd1;
              if (bitn == 3'd7) begin
                cnt <= cnt - CNT_W'(1);
                fin <= '0;
                if (!wr_q) begin
                  rx_data <= rxsh;
                  rx_req  <= 1'b1;
                  st      <= S_HAND;
                end else begin
                  st <= (cnt == CNT_W'(1)) ? S_FIN : S_LOAD;
                end
              end
            end
          end
        end
        S_HAND: if (rx_ack) begin
          rx_req <= 1'b0;
          st     <= (cnt == '0) ? S_FIN : S_LOAD;
        end
        S_FIN: begin
          if (fin == {div_q, 1'b1}) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else fin <= fin + (DIV_W+1)'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_bulk_engine_chk.sv
module spi_bulk_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       sclk,
  input logic       mosi,
  input logic       cs_n,
  input logic       busy,
  input logic       done,
  input logic       rx_req,
  input logic       rx_ack,
  input logic [7:0] rx_data,
  input logic       wr_q
);
  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_mosi_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));
  p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !wr_q) |-> mosi);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && !rx_ack) |=> (rx_req && $stable(rx_data)));
  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> !sclk);
  p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_q) |-> !rx_req);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy));
  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(wr_q));
endmodule

bind spi_bulk_engine spi_bulk_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sclk(sclk), .mosi(mosi),
  .cs_n(cs_n), .busy(busy), .done(done), .rx_req(rx_req), .rx_ack(rx_ack),
  .rx_data(rx_data), .wr_q(wr_q)
);

// File: tb/spi_bulk_engine_bench.sv
module spi_bulk_engine_bench;
  logic       clk = 0, rst_n = 0, start = 0, write_mode = 0;
  logic [9:0] byte_count = '0;
  logic [3:0] clk_div = '0;
  logic [7:0] tx_data = '0, rx_data;
  logic       tx_ack = 0, tx_req, rx_req, rx_ack = 0;
  logic       sclk, mosi, miso = 1, cs_n, busy, done;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  spi_bulk_engine u_spi_bulk_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .write_mode(write_mode),
    .byte_count(byte_count), .clk_div(clk_div), .tx_data(tx_data),
    .tx_ack(tx_ack), .tx_req(tx_req), .rx_data(rx_data), .rx_req(rx_req),
    .rx_ack(rx_ack), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .busy(busy), .done(done)
  );

  // {write, count[10], div[4], seed[8], ack_delay[4]}
  localparam logic [26:0] VEC [0:5] = '{
    {1'b0, 10'd4,   4'd0, 8'h3C, 4'd0},
    {1'b0, 10'd3,   4'd2, 8'hA5, 4'd3},
    {1'b1, 10'd5,   4'd1, 8'h10, 4'd0},
    {1'b1, 10'd2,   4'd3, 8'hF0, 4'd0},
    {1'b0, 10'd512, 4'd0, 8'h01, 4'd0},
    {1'b0, 10'd1,   4'd5, 8'h7E, 4'd1}
  };

  function automatic logic [7:0] fmiso(logic [7:0] s, int i);
    return s + 8'(i * 29);
  endfunction
  function automatic logic [7:0] ftx(logic [7:0] s, int i);
    return s ^ 8'(i * 53);
  endfunction

  task automatic chk(string req, bit ok, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(bit wr, int cnt, int d, logic [7:0] seed, int dly, bit poke);
    int hi_cnt = 0, since_fall = 0, sbit = 0, sidx = 0, mbits = 0, mbyte = 0;
    int txi = 0, rxi = 0, wcnt = 0, n = 0;
    int hp_bad = 0, mosi_bad = 0, rx_bad = 0, stall_bad = 0, cs_bad = 0, rx_seen = 0;
    logic [7:0] msh = '0, sb;
    bit ps = 0, pcs = 1;
    sb = fmiso(seed, 0);
    miso = sb[7];
    write_mode = wr; byte_count = cnt[9:0]; clk_div = d[3:0];
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R9 done cleared by start", done == 0, done, 0);
    while (1) begin
      n++;
      if (poke && n == 20) begin start = 1; write_mode = 1; byte_count = 10'd9; end
      if (poke && n == 21) begin start = 0; write_mode = wr; byte_count = cnt[9:0]; end
      hi_cnt++; since_fall++;
      if (ps && !sclk) begin
        if (hi_cnt != d + 1) hp_bad++;
        since_fall = 0;
        sbit++;
        if (sbit == 8) begin sbit = 0; sidx++; end
        sb = fmiso(seed, sidx);
        miso = sb[7 - sbit];
      end
      if (!ps && sclk) begin
        hi_cnt = 0;
        msh = {msh[6:0], mosi};
        mbits++;
        if (mbits == 8) begin
          mbits = 0;
          if (msh != (wr ? ftx(seed, mbyte) : 8'hFF)) mosi_bad++;
          mbyte++;
        end
      end
      if (!pcs && cs_n && wr && since_fall != 2 * (d + 1)) cs_bad++;
      ps = sclk; pcs = cs_n;
      if (tx_ack) tx_ack = 0;
      else if (tx_req) begin tx_data = ftx(seed, txi); tx_ack = 1; txi++; end
      if (rx_ack) rx_ack = 0;
      else if (rx_req) begin
        rx_seen++;
        if (wcnt < dly) begin
          wcnt++;
          if (sclk) stall_bad++;
        end else begin
          wcnt = 0;
          if (rx_data != fmiso(seed, rxi)) rx_bad++;
          rxi++;
          rx_ack = 1;
        end
      end
      if (done) break;
      @(negedge clk);
    end
    chk("R7 frame count", mbyte == cnt, mbyte, cnt);
    chk("R2 high phase length", hp_bad == 0, hp_bad, 0);
    if (!wr) begin
      chk("R3 fill bytes", mosi_bad == 0, mosi_bad, 0);
      chk("R4 received data", rx_bad == 0 && rxi == cnt, rxi, cnt);
      chk("R5 stall while pending", stall_bad == 0, stall_bad, 0);
    end else begin
      chk("R6 transmit data", mosi_bad == 0 && txi == cnt, txi, cnt);
      chk("R6 no receive request", rx_seen == 0, rx_seen, 0);
      chk("R8 cs release delay", cs_bad == 0, cs_bad, 0);
    end
    chk("R9 done with idle", done && !busy && cs_n, {done, busy, cs_n}, 3'b101);
    if (poke) chk("R10 start ignored while busy", mbyte == cnt, mbyte, cnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R7 watchdog expired: actual 0 expected 1");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", cs_n && !sclk && mosi && !done && !busy && !rx_req && !tx_req,
        {cs_n, sclk, mosi, done, busy, rx_req, tx_req}, 7'b1010000);
    for (int i = 0; i < 6; i++) begin
      logic [26:0] v;
      v = VEC[i];
      run_case(v[26], int'(v[25:16]), int'(v[15:12]), v[11:4], int'(v[3:0]), 1'b0);
    end
    repeat (10) @(negedge clk);
    chk("R9 done held while idle", done == 1, done, 1);
    write_mode = 0; byte_count = '0; start = 1;
    @(negedge clk);
    start = 0;
    chk("R7 zero count done", done == 1, done, 1);
    begin
      int low = 0;
      for (int k = 0; k < 5; k++) begin
        if (!cs_n) low++;
        @(negedge clk);
      end
      chk("R7 zero count keeps cs high", low == 0, low, 0);
    end
    run_case(1'b0, 3, 2, 8'h55, 0, 1'b1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule